// File: doc/BRIEF.md
# Stereo PDM Microphone Receiver

This block serves a pair of pulse-density-modulated microphones that share one bit clock and one data wire. It divides the system clock down to a microphone clock at 64 times the output frame rate. Each microphone drives the shared data line during one half of that clock. A polarity input selects which half belongs to the left channel. The block samples one bit per half period and steers it to the matching channel. For each channel it counts the ones over 64 microphone clock periods. It then turns each count into a signed 24-bit sample and presents the left and right samples together with a one-cycle valid strobe.

When the enable input is low, the microphone clock stays low and nothing is captured or produced. Any partial frame that was collecting is dropped. The block runs in the system clock domain only. The ratio of microphone clock to frame rate is fixed by the decimation factor.

Top module: `pdm_stereo_rx`

## Requirements
- R1: While enabled, the microphone clock has a period of CLK_DIV system cycles, CLK_DIV/2 cycles low and CLK_DIV/2 cycles high. After enable rises it starts with a full low half.
- R2: A cycle with enable low forces the microphone clock low and the valid strobe low at the next edge. The frame in progress is discarded, and the next enable starts a fresh frame.
- R3: With the polarity selection at 1, bits present during the high half go to the left channel and bits present during the low half go to the right channel.
- R4: With the polarity selection at 0, bits present during the high half go to the right channel and bits present during the low half go to the left channel. Reset sets the polarity in use to 0.
- R5: A change of the polarity input takes effect only at a frame boundary or while disabled. Every frame uses one polarity from start to finish.
- R6: The bit for a half period is taken in the last system cycle of that half. Values on the data line earlier in the half have no effect.
- R7: Every 64 microphone clock periods (128 halves), the left and right outputs update on the same edge and valid is high for exactly one cycle. Between strobes both outputs hold their values.
- R8: A channel with n ones in its 64 bits outputs n·2^18 − 2^23 as a two's-complement 24-bit value. n = 64 saturates to 0x7FFFFF, n = 0 gives 0x800000 and n = 32 gives 0.
- R9: A synchronous reset clears both outputs to 0, holds valid low and forces the microphone clock low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| clk_en_i | input | 1 | Microphone clock enable |
| pol_i | input | 1 | Polarity selection: 1 puts the left channel in the high half |
| pdm_data_i | input | 1 | Shared microphone data line |
| pdm_clk_o | output | 1 | Microphone clock |
| left_o | output | 24 | Left channel sample, two's complement |
| right_o | output | 24 | Right channel sample, two's complement |
| valid_o | output | 1 | One-cycle strobe marking new samples |

## Verification
Some properties are checked on every cycle: the length of each clock half, the forced-low clock and silent strobe while disabled, the single-cycle strobe with both samples held between strobes, and that the polarity in use changes only at a frame edge or while disabled. Only the bench scenarios can show that bits go to the correct channel under each polarity. The same holds for full-scale mapping at the 0, 32 and 64 counts, for data that changes mid-half being ignored, and for a frame cut short by a disable producing no sample.

// File: rtl/pdm_mic_pkg.sv
package pdm_mic_pkg;

    // Channel slot indices used for the per-channel generate
    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } pdm_chan_e;

    localparam int PDM_NUM_CH = 2;

endpackage

// File: rtl/pdm_clk_div.sv
module pdm_clk_div #(
    parameter int CLK_DIV = 8
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic en_i,
    output logic mclk_o,
    output logic cap_o,
    output logic phase_o
);
    localparam int HALF = CLK_DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mclk;
    } div_state_t;

    localparam div_state_t DIV_RESET = '{cnt: '0, mclk: 1'b0};

    div_state_t st_d, st_q;
    logic       half_end;

    assign half_end = (st_q.cnt == CW'(HALF - 1));

    always_comb begin
        st_d = st_q;
        if (!en_i) begin
            st_d.cnt  = '0;
            st_d.mclk = 1'b0;
        end else if (half_end) begin
            st_d.cnt  = '0;
            st_d.mclk = ~st_q.mclk;
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= DIV_RESET;
        else       st_q <= st_d;
    end

    assign mclk_o  = st_q.mclk;
    assign cap_o   = en_i && half_end;
    assign phase_o = st_q.mclk;

endmodule

// File: rtl/pdm_ones_acc.sv
module pdm_ones_acc #(
    parameter int DEC = 64
) (
    input  logic                     clk_i,
    input  logic                     rst_i,
    input  logic                     clear_i,
    input  logic                     add_i,
    input  logic                     bit_i,
    input  logic                     flush_i,
    output logic [$clog2(DEC+1)-1:0] total_o
);
    localparam int CW = $clog2(DEC + 1);

    typedef struct packed {
        logic [CW-1:0] ones;
    } acc_state_t;

    acc_state_t st_d, st_q;

    // Running count including a bit being taken on this very cycle
    assign total_o = st_q.ones + CW'(add_i && bit_i);

    always_comb begin
        st_d = st_q;
        if (clear_i || flush_i) st_d.ones = '0;
        else if (add_i)         st_d.ones = total_o;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

endmodule

// File: rtl/pdm_fs_map.sv
module pdm_fs_map #(
    parameter int DEC   = 64,
    parameter int OUT_W = 24
) (
    input  logic [$clog2(DEC+1)-1:0] count_i,
    output logic [OUT_W-1:0]         sample_o
);
    localparam int DBITS = $clog2(DEC);
    localparam int SHIFT = OUT_W - DBITS;

    logic             sat;
    logic [OUT_W-1:0] body;

    // count == DEC is the only value with the top bit set (DEC a power of two)
    assign sat  = count_i[DBITS];
    assign body = {count_i[DBITS-1:0], {SHIFT{1'b0}}};

    always_comb begin
        if (sat) sample_o = {1'b0, {(OUT_W-1){1'b1}}};
        else     sample_o = {~body[OUT_W-1], body[OUT_W-2:0]};
    end

endmodule

// File: rtl/pdm_stereo_rx.sv
module pdm_stereo_rx
    import pdm_mic_pkg::*;
#(
    parameter int CLK_DIV = 8,
    parameter int DEC     = 64,
    parameter int OUT_W   = 24
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             clk_en_i,
    input  logic             pol_i,
    input  logic             pdm_data_i,
    output logic             pdm_clk_o,
    output logic [OUT_W-1:0] left_o,
    output logic [OUT_W-1:0] right_o,
    output logic             valid_o
);
    localparam int SLOTS = 2 * DEC;
    localparam int SW    = $clog2(SLOTS);
    localparam int CW    = $clog2(DEC + 1);

    typedef struct packed {
        logic [SW-1:0]    slot;
        logic             pol;
        logic [OUT_W-1:0] left;
        logic [OUT_W-1:0] right;
        logic             valid;
    } rx_state_t;

    localparam rx_state_t RX_RESET = '{slot: '0, pol: 1'b0, left: '0, right: '0, valid: 1'b0};

    rx_state_t st_d, st_q;

    logic             cap;
    logic             phase;
    logic             frame_end;
    logic             pol_q;
    logic [CW-1:0]    total    [PDM_NUM_CH];
    logic [OUT_W-1:0] mapped   [PDM_NUM_CH];

    assign pol_q     = st_q.pol;
    assign frame_end = cap && (st_q.slot == SW'(SLOTS - 1));

    pdm_clk_div #(.CLK_DIV(CLK_DIV)) u_div (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .en_i    (clk_en_i),
        .mclk_o  (pdm_clk_o),
        .cap_o   (cap),
        .phase_o (phase)
    );

    for (genvar ch = 0; ch < PDM_NUM_CH; ch++) begin : g_ch
        logic take;
        // Left owns the half whose level equals the polarity in use
        if (ch == int'(CH_LEFT)) begin : g_left
            assign take = cap && (phase == st_q.pol);
        end else begin : g_right
            assign take = cap && (phase != st_q.pol);
        end

        pdm_ones_acc #(.DEC(DEC)) u_acc (
            .clk_i   (clk_i),
            .rst_i   (rst_i),
            .clear_i (!clk_en_i),
            .add_i   (take),
            .bit_i   (pdm_data_i),
            .flush_i (frame_end),
            .total_o (total[ch])
        );

        pdm_fs_map #(.DEC(DEC), .OUT_W(OUT_W)) u_map (
            .count_i  (total[ch]),
            .sample_o (mapped[ch])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (!clk_en_i) begin
            st_d.slot = '0;
            st_d.pol  = pol_i;
        end else if (frame_end) begin
            st_d.slot  = '0;
            st_d.pol   = pol_i;
            st_d.left  = mapped[int'(CH_LEFT)];
            st_d.right = mapped[int'(CH_RIGHT)];
            st_d.valid = 1'b1;
        end else if (cap) begin
            st_d.slot = st_q.slot + SW'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= RX_RESET;
        else       st_q <= st_d;
    end

    assign left_o  = st_q.left;
    assign right_o = st_q.right;
    assign valid_o = st_q.valid;

endmodule

// File: rtl/pdm_stereo_rx_chk.sv
module pdm_stereo_rx_chk #(
    parameter int CLK_DIV = 8,
    parameter int OUT_W   = 24
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             clk_en_i,
    input logic             pdm_clk_o,
    input logic             valid_o,
    input logic [OUT_W-1:0] left_o,
    input logic [OUT_W-1:0] right_o,
    input logic             pol_q
);
    localparam int HALF = CLK_DIV / 2;
    localparam int RW   = $clog2(HALF + 2);

    logic [RW-1:0] hi_run_q;
    logic [RW-1:0] lo_run_q;

    // Run-length counters of each clock level, saturating
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            hi_run_q <= '0;
            lo_run_q <= '0;
        end else begin
            if (!pdm_clk_o)                    hi_run_q <= '0;
            else if (hi_run_q != RW'(HALF + 1)) hi_run_q <= hi_run_q + RW'(1);
            if (pdm_clk_o || !clk_en_i)        lo_run_q <= '0;
            else if (lo_run_q != RW'(HALF + 1)) lo_run_q <= lo_run_q + RW'(1);
        end
    end

    p_high_len_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        ($fell(pdm_clk_o) && $past(clk_en_i)) |-> (hi_run_q == RW'(HALF)));

    p_low_len_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(pdm_clk_o) |-> (lo_run_q == RW'(HALF)));

    p_clk_off_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        !clk_en_i |=> !pdm_clk_o);

    p_quiet_off_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        !clk_en_i |=> !valid_o);

    p_pol_frame_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (pol_q != $past(pol_q)) |-> (!$past(clk_en_i) || valid_o));

    p_strobe_single_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o |=> !valid_o);

    p_hold_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        !valid_o |-> ($stable(left_o) && $stable(right_o)));

endmodule

bind pdm_stereo_rx pdm_stereo_rx_chk #(.CLK_DIV(CLK_DIV), .OUT_W(OUT_W)) u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .clk_en_i  (clk_en_i),
    .pdm_clk_o (pdm_clk_o),
    .valid_o   (valid_o),
    .left_o    (left_o),
    .right_o   (right_o),
    .pol_q     (pol_q)
);

// File: tb/test_pdm_stereo_rx.sv
module test_pdm_stereo_rx;
    localparam int CLK_DIV = 8;
    localparam int HALF    = CLK_DIV / 2;

    logic        clk_i = 1'b0;
    logic        rst_i = 1'b1;
    logic        clk_en_i = 1'b0;
    logic        pol_i = 1'b0;
    logic        pdm_data_i = 1'b0;
    logic        pdm_clk_o;
    logic [23:0] left_o;
    logic [23:0] right_o;
    logic        valid_o;

    int tests = 0;
    int fails = 0;
    int exp_l[$];
    int exp_r[$];

    always #2.5 clk_i = ~clk_i;

    pdm_stereo_rx #(.CLK_DIV(CLK_DIV)) i_pdm_stereo_rx (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .clk_en_i   (clk_en_i),
        .pol_i      (pol_i),
        .pdm_data_i (pdm_data_i),
        .pdm_clk_o  (pdm_clk_o),
        .left_o     (left_o),
        .right_o    (right_o),
        .valid_o    (valid_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // R8: n ones -> n*2^18 - 2^23, saturating at 64
    function automatic int fs_val(input int n);
        return (n == 64) ? 8388607 : n * 262144 - 8388608;
    endfunction

    // Spreads k ones evenly over 64 positions
    function automatic logic pat(input int j, input int k);
        return (((j + 1) * k) / 64) != ((j * k) / 64);
    endfunction

    // Drives nph halves starting on a low half; optionally queues the expected frame
    task automatic stream(input int kl, input int kr, input bit push, input int nph,
                          input int flip_at, input bit late, input bit chk_clk);
        logic pe;
        pe = pol_i;
        if (push) begin
            exp_l.push_back(fs_val(kl));
            exp_r.push_back(fs_val(kr));
        end
        for (int p = 0; p < nph; p++) begin
            logic lvl;
            logic b;
            lvl = p[0];
            b   = (lvl == pe) ? pat(p / 2, kl) : pat(p / 2, kr);
            for (int c = 0; c < HALF; c++) begin
                // R6: wrong value on the line except in the last cycle of the half
                pdm_data_i = (late && c < HALF - 1) ? ~b : b;
                if (chk_clk) chk("R1 clock level", int'(pdm_clk_o), int'(lvl));
                if (p == flip_at && c == 0) pol_i = ~pol_i;
                @(negedge clk_i);
            end
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk_i) begin
        if (!rst_i && valid_o) begin
            if (exp_l.size() == 0) begin
                tests++;
                fails++;
                $display("FAIL R7 unexpected strobe: actual 1 expected 0");
            end else begin
                chk("R3 R4 R8 left sample", int'($signed(left_o)), exp_l.pop_front());
                chk("R3 R4 R8 right sample", int'($signed(right_o)), exp_r.pop_front());
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk_i);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk_i);
        // R9 reset state
        chk("R9 clock low", int'(pdm_clk_o), 0);
        chk("R9 valid low", int'(valid_o), 0);
        chk("R9 left zero", int'(left_o), 0);
        chk("R9 right zero", int'(right_o), 0);
        rst_i = 1'b0;

        // R2: disabled, nothing toggles
        for (int i = 0; i < 16; i++) begin
            @(negedge clk_i);
            chk("R2 clock held low", int'(pdm_clk_o), 0);
            chk("R2 no strobe", int'(valid_o), 0);
        end

        // R1 R4: default polarity, clock shape checked on the first frame
        clk_en_i = 1'b1;
        stream(10, 50, 1'b1, 128, -1, 1'b0, 1'b1);
        // R8 extremes and mid-scale
        stream(64, 0, 1'b1, 128, -1, 1'b0, 1'b0);
        stream(0, 64, 1'b1, 128, -1, 1'b0, 1'b0);
        // R5: polarity flipped mid-frame must not affect this frame
        stream(32, 33, 1'b1, 128, 40, 1'b0, 1'b0);
        // R3: polarity 1 now in use
        stream(7, 60, 1'b1, 128, -1, 1'b0, 1'b0);
        // R6: only the final cycle of each half counts
        stream(48, 16, 1'b1, 128, -1, 1'b1, 1'b0);

        // R2: partial frame then disable; it must produce nothing
        stream(20, 20, 1'b0, 70, -1, 1'b0, 1'b0);
        clk_en_i = 1'b0;
        pol_i    = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk_i);
            chk("R2 clock low when disabled", int'(pdm_clk_o), 0);
            chk("R2 no strobe when disabled", int'(valid_o), 0);
        end
        // R4 R5: polarity taken while disabled, fresh frame after enable
        clk_en_i = 1'b1;
        stream(5, 59, 1'b1, 128, -1, 1'b0, 1'b1);

        repeat (3) @(negedge clk_i);
        chk("R7 every frame produced one sample", exp_l.size(), 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule